// File: doc/BRIEF.md
# Variable Page Size Unified TLB

This block is a software-managed translation lookaside buffer, shared by the instruction fetch and data access paths. It holds a parameterized number of entries, 64 by default. Each entry pairs a tag word with a data word. Hardware never fills the buffer. Software loads entries, reads them back and invalidates them through a register-style port. That port takes an entry index, a word select and write data.

Every entry carries its own page-size code, from 1 KB to 16 MB in steps of four. The number of effective-address bits that take part in the compare therefore differs from entry to entry. The same code sets the number of physical-page bits that replace address bits in the result. A lookup port searches all entries in parallel for a 32-bit effective address. After one register stage it returns the following:
- a hit flag
- the winning index
- the translated physical address
- the execute and write permissions
- the zone select
- the four storage attributes

Zone-based protection, refill and exceptions belong to the surrounding logic.

Top module: `tlb_unified`

## Requirements
- R1: After reset every entry is invalid and reads back as zero. The lookup outputs are all zero and `hit` is low.
- R2: Word select 0 addresses the tag word. In that word, bits 31:10 are the effective page number, bits 9:7 the page-size code and bit 6 the valid flag.
- R3: For size code s (0..7, meaning 1K, 4K, 16K, 64K, 256K, 1M, 4M, 16M), the compare ignores the low 10+2s address bits. An address that differs from the page number in a bit at or above 10+2s does not match.
- R4: On a hit, the physical address takes bits 31:10+2s from the real page number (data bits 31:10) and the low 10+2s bits from the effective address.
- R5: Word select 1 addresses the data word. On a hit, `lkp_exec` is data bit 9 and `lkp_write` is bit 8. `lkp_zone` is bits 7:4. `lkp_attr` is bits 3:0, where bit 3 is write-through, bit 2 is cache-inhibited, bit 1 is coherent and bit 0 is guarded.
- R6: Only entries whose valid flag is set can match. When several match, the lowest index wins and is given on `lkp_idx`.
- R7: On a miss, `hit` and all other lookup outputs are zero.
- R8: Lookup results appear one clock after the address is presented. A software write is seen by lookups from the cycle after the write edge onward.
- R9: `sw_rdata` gives the word chosen by `sw_idx` and `sw_sel` one clock later.
- R10: `inv_all` clears every valid flag in one cycle and leaves all other stored bits as they were.
- R11: `inv_page_en` clears the valid flag of every entry that would match the page number `inv_page`, and only those entries.
- R12: When a write and an invalidation hit the same entry in the same cycle, the written word is stored but its valid flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_idx | input | IDX_W | Entry index for software read/write |
| sw_sel | input | 1 | Word select: 0 tag, 1 data |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Registered software read data |
| inv_all | input | 1 | Clear all valid flags |
| inv_page_en | input | 1 | Clear valid flags of entries matching `inv_page` |
| inv_page | input | 22 | Effective address bits 31:10 for invalidation |
| lkp_va | input | 32 | Lookup effective address |
| lkp_hit | output | 1 | Registered hit flag |
| lkp_idx | output | IDX_W | Winning entry index |
| lkp_pa | output | 32 | Translated physical address |
| lkp_exec | output | 1 | Execute permission |
| lkp_write | output | 1 | Write permission |
| lkp_zone | output | 4 | Zone select |
| lkp_attr | output | 4 | Storage attributes (W, I, M, G) |

## Verification
The bench builds the block with its default of 64 entries and a 6-bit index. This puts index 63 and a priority contest between widely separated indices within reach. All eight page-size codes are exercised, each just inside and just outside its page boundary. That covers the shortest and the longest compare masks on the same instance.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PN_W = 22;
    localparam int PG_LSB = 10;

    typedef struct packed {
        logic [PN_W-1:0] epn;
        logic [2:0]      size;
        logic            valid;
        logic [5:0]      spare;
    } tag_t;

    typedef struct packed {
        logic [PN_W-1:0] rpn;
        logic            ex;
        logic            wr;
        logic [3:0]      zone;
        logic [3:0]      attr;
    } data_t;

    typedef struct packed {
        logic [PN_W-1:0] epn;
        logic [2:0]      size;
        logic            valid;
    } key_t;

    // Page-number bits that take part in the compare for a size code.
    function automatic logic [PN_W-1:0] pn_mask(input logic [2:0] sz);
        return ~((22'd1 << {sz, 1'b0}) - 22'd1);
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  key_t [ENTRIES-1:0]  keys_i,
    input  logic [PN_W-1:0]     pn_i,
    output logic [ENTRIES-1:0]  match_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [PN_W-1:0] mask_c;
        always_comb begin
            mask_c     = pn_mask(keys_i[g].size);
            match_o[g] = keys_i[g].valid && (((pn_i ^ keys_i[g].epn) & mask_c) == '0);
        end
    end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] match_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [ENTRIES-1:0] sel_o
);
    always_comb begin
        found_o = |match_i;
        idx_o   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_i[i]) idx_o = IDX_W'(i);
        end
        sel_o = match_i & ~(match_i - 1'b1);
    end

    p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));
    p_sel_is_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (sel_o[idx_o] && match_i[idx_o]));
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   widx_i,
    input  logic               wsel_i,
    input  logic [31:0]        wdata_i,
    input  logic               inv_all_i,
    input  logic [ENTRIES-1:0] inv_clr_i,
    input  logic [IDX_W-1:0]   ridx_i,
    input  logic               rsel_i,
    output logic [31:0]        rword_o,
    output key_t [ENTRIES-1:0] keys_o,
    output data_t [ENTRIES-1:0] data_o
);
    typedef struct packed {
        tag_t  [ENTRIES-1:0] tag;
        data_t [ENTRIES-1:0] data;
    } st_t;

    st_t st_d, st_q;
    logic [ENTRIES-1:0] valid_vec;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            if (wsel_i) st_d.data[widx_i] = data_t'(wdata_i);
            else        st_d.tag[widx_i]  = tag_t'(wdata_i);
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (inv_all_i || inv_clr_i[i]) st_d.tag[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_out
        assign keys_o[g].epn   = st_q.tag[g].epn;
        assign keys_o[g].size  = st_q.tag[g].size;
        assign keys_o[g].valid = st_q.tag[g].valid;
        assign valid_vec[g]    = st_q.tag[g].valid;
    end
    assign data_o  = st_q.data;
    assign rword_o = rsel_i ? 32'(st_q.data[ridx_i]) : 32'(st_q.tag[ridx_i]);

    p_inv_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all_i |=> (valid_vec == '0));
    p_tag_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wsel_i && !inv_all_i && (inv_clr_i == '0))
            |=> (32'(st_q.tag[$past(widx_i)]) == $past(wdata_i)));
endmodule

// File: rtl/tlb_unified.sv
module tlb_unified
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic             sw_sel,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    input  logic             inv_all,
    input  logic             inv_page_en,
    input  logic [21:0]      inv_page,
    input  logic [31:0]      lkp_va,
    output logic             lkp_hit,
    output logic [IDX_W-1:0] lkp_idx,
    output logic [31:0]      lkp_pa,
    output logic             lkp_exec,
    output logic             lkp_write,
    output logic [3:0]       lkp_zone,
    output logic [3:0]       lkp_attr
);
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [31:0]      pa;
        logic             ex;
        logic             wr;
        logic [3:0]       zone;
        logic [3:0]       attr;
        logic [31:0]      rdata;
    } out_t;

    key_t  [ENTRIES-1:0] keys;
    data_t [ENTRIES-1:0] datas;
    logic  [ENTRIES-1:0] lkp_match, inv_match, inv_clr, sel_vec;
    logic  [31:0]        rword;
    logic                found;
    logic  [IDX_W-1:0]   win_idx;
    out_t                out_d, out_q;

    assign inv_clr = inv_page_en ? inv_match : '0;

    tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_i(sw_we), .widx_i(sw_idx), .wsel_i(sw_sel), .wdata_i(sw_wdata),
        .inv_all_i(inv_all), .inv_clr_i(inv_clr),
        .ridx_i(sw_idx), .rsel_i(sw_sel), .rword_o(rword),
        .keys_o(keys), .data_o(datas)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_match_lkp (
        .keys_i(keys), .pn_i(lkp_va[31:PG_LSB]), .match_o(lkp_match)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_match_inv (
        .keys_i(keys), .pn_i(inv_page), .match_o(inv_match)
    );

    tlb_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .match_i(lkp_match),
        .found_o(found), .idx_o(win_idx), .sel_o(sel_vec)
    );

    always_comb begin
        logic [31:0] mask32;
        data_t       dw;
        out_d       = '0;
        out_d.rdata = rword;
        dw          = datas[win_idx];
        mask32      = {pn_mask(keys[win_idx].size), 10'b0};
        if (found) begin
            out_d.hit  = 1'b1;
            out_d.idx  = win_idx;
            out_d.pa   = ({dw.rpn, 10'b0} & mask32) | (lkp_va & ~mask32);
            out_d.ex   = dw.ex;
            out_d.wr   = dw.wr;
            out_d.zone = dw.zone;
            out_d.attr = dw.attr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sw_rdata  = out_q.rdata;
    assign lkp_hit   = out_q.hit;
    assign lkp_idx   = out_q.idx;
    assign lkp_pa    = out_q.pa;
    assign lkp_exec  = out_q.ex;
    assign lkp_write = out_q.wr;
    assign lkp_zone  = out_q.zone;
    assign lkp_attr  = out_q.attr;

    p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_hit |-> (lkp_pa == '0 && lkp_idx == '0 && !lkp_exec && !lkp_write
                      && lkp_zone == '0 && lkp_attr == '0));
    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_hit |-> (lkp_pa[9:0] == $past(lkp_va[9:0])));
    p_hit_needs_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_match == '0) |=> !lkp_hit);
endmodule

// File: tb/tb_tlb_unified.sv
`timescale 1ns/1ps
module tb_tlb_unified;
    localparam int N = 64;
    localparam int IW = 6;

    logic clk = 0, rst_n = 0;
    logic sw_we = 0, sw_sel = 0, inv_all = 0, inv_page_en = 0;
    logic [IW-1:0] sw_idx = '0;
    logic [31:0] sw_wdata = '0, lkp_va = '0, sw_rdata, lkp_pa;
    logic [21:0] inv_page = '0;
    logic lkp_hit, lkp_exec, lkp_write;
    logic [IW-1:0] lkp_idx;
    logic [3:0] lkp_zone, lkp_attr;

    logic [31:0] tag_m [N];
    logic [31:0] dat_m [N];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tlb_unified #(.ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_idx(sw_idx), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .inv_all(inv_all),
        .inv_page_en(inv_page_en), .inv_page(inv_page), .lkp_va(lkp_va),
        .lkp_hit(lkp_hit), .lkp_idx(lkp_idx), .lkp_pa(lkp_pa), .lkp_exec(lkp_exec),
        .lkp_write(lkp_write), .lkp_zone(lkp_zone), .lkp_attr(lkp_attr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] keep_mask(input logic [2:0] s);
        return ~((32'd1 << (10 + 2 * s)) - 32'd1);
    endfunction

    function automatic logic [31:0] tagw(input logic [31:0] va, input logic [2:0] s, input logic v);
        return (va & 32'hFFFF_FC00) | (32'(s) << 7) | (32'(v) << 6);
    endfunction

    // Expected lookup from the shadow copy: {hit, idx, pa, data[9:0]}
    task automatic model(input logic [31:0] va, output logic h, output logic [IW-1:0] ix,
                         output logic [31:0] pa, output logic [9:0] fl);
        h = 0; ix = '0; pa = '0; fl = '0;
        for (int i = 0; i < N; i++) begin
            logic [31:0] m;
            m = keep_mask(tag_m[i][9:7]);
            if (!h && tag_m[i][6] && (((va ^ tag_m[i]) & m) == 0)) begin
                h = 1; ix = IW'(i);
                pa = (dat_m[i] & m) | (va & ~m);
                fl = dat_m[i][9:0];
            end
        end
    endtask

    task automatic sw_write(input int idx, input logic sel, input logic [31:0] w);
        @(negedge clk);
        sw_we = 1; sw_idx = IW'(idx); sw_sel = sel; sw_wdata = w;
        @(negedge clk);
        sw_we = 0;
        if (sel) dat_m[idx] = w; else tag_m[idx] = w;
    endtask

    task automatic look(input string req, input logic [31:0] va);
        logic h; logic [IW-1:0] ix; logic [31:0] pa; logic [9:0] fl;
        @(negedge clk);
        lkp_va = va;
        @(negedge clk);
        model(va, h, ix, pa, fl);
        chk({req, " hit"}, 32'(lkp_hit), 32'(h));
        chk({req, " idx"}, 32'(lkp_idx), 32'(ix));
        chk({req, " pa"}, lkp_pa, pa);
        chk({req, " flags"}, 32'({lkp_exec, lkp_write, lkp_zone, lkp_attr}), 32'(fl));
    endtask

    task automatic readback(input string req, input int idx, input logic sel, input logic [31:0] exp);
        @(negedge clk);
        sw_idx = IW'(idx); sw_sel = sel;
        @(negedge clk);
        chk(req, sw_rdata, exp);
    endtask

    task automatic t_reset;
        chk("R1 hit", 32'(lkp_hit), 0);
        chk("R1 pa", lkp_pa, 0);
        readback("R1 tag0", 0, 0, 0);
        readback("R1 data63", 63, 1, 0);
        look("R1 lookup", 32'h0000_0000);
    endtask

    task automatic t_basic;
        sw_write(3, 1, 32'hABCD_E000 | 32'h3A5);   // ex=1 wr=1 zone=A attr=5
        sw_write(3, 0, tagw(32'h1234_5000, 3'd1, 1));
        look("R2 R5 4K hit", 32'h1234_5ABC);
        look("R4 4K pa", 32'h1234_5FFF);
        look("R7 miss outside", 32'h1234_6000);
    endtask

    task automatic t_sizes;
        for (int s = 0; s < 8; s++) begin
            logic [31:0] base;
            base = 32'(s + 1) << 28;
            sw_write(10 + s, 1, (32'h8000_0000 | 32'(s) << 24) | 32'h1F0 | 32'(s));
            sw_write(10 + s, 0, tagw(base, 3'(s), 1));
            look("R3 R4 inside", base | ((32'd1 << (10 + 2 * s)) - 32'd1));
            look("R3 outside", base | (32'd1 << (10 + 2 * s)));
        end
    endtask

    task automatic t_priority;
        sw_write(2, 0, tagw(32'h5000_0000, 3'd7, 0));   // invalid, must not win
        sw_write(40, 1, 32'h0100_0200);
        sw_write(40, 0, tagw(32'h5000_0000, 3'd7, 1));
        sw_write(5, 1, 32'h0200_0100);
        sw_write(5, 0, tagw(32'h5012_0000, 3'd5, 1));
        look("R6 lowest wins", 32'h5012_3456);
        sw_write(5, 0, tagw(32'h5012_0000, 3'd5, 0));
        look("R6 next after drop", 32'h5012_3456);
        sw_write(63, 1, 32'hFFFF_FC0F);
        sw_write(63, 0, tagw(32'hEEEE_E400, 3'd0, 1));
        look("R6 index 63", 32'hEEEE_E7FF);
    endtask

    task automatic t_timing;
        @(negedge clk);
        sw_we = 1; sw_idx = IW'(20); sw_sel = 0;
        sw_wdata = tagw(32'h7700_0000, 3'd2, 1);
        lkp_va = 32'h7700_0123;
        @(negedge clk);
        sw_we = 0; tag_m[20] = tagw(32'h7700_0000, 3'd2, 1);
        chk("R8 old content during write", 32'(lkp_hit), 0);
        @(negedge clk);
        chk("R8 new content next cycle", 32'(lkp_hit), 1);
        chk("R8 idx", 32'(lkp_idx), 20);
    endtask

    task automatic t_readback;
        readback("R9 tag", 3, 0, tag_m[3]);
        readback("R9 data", 3, 1, dat_m[3]);
    endtask

    task automatic t_inv_page;
        @(negedge clk);
        inv_page_en = 1; inv_page = 22'(32'h1234_5000 >> 10);
        @(negedge clk);
        inv_page_en = 0;
        tag_m[3][6] = 0;
        readback("R11 cleared tag", 3, 0, tag_m[3]);
        look("R11 cleared miss", 32'h1234_5000);
        look("R11 others kept", 32'h7700_0123);
    endtask

    task automatic t_inv_all;
        @(negedge clk);
        inv_all = 1;
        @(negedge clk);
        inv_all = 0;
        for (int i = 0; i < N; i++) tag_m[i][6] = 0;
        look("R10 all miss", 32'h5000_0000);
        readback("R10 fields kept", 40, 0, tag_m[40]);
        readback("R10 data kept", 40, 1, dat_m[40]);
    endtask

    task automatic t_collide;
        @(negedge clk);
        sw_we = 1; sw_idx = IW'(7); sw_sel = 0;
        sw_wdata = tagw(32'h3300_0000, 3'd4, 1); inv_all = 1;
        @(negedge clk);
        sw_we = 0; inv_all = 0;
        tag_m[7] = tagw(32'h3300_0000, 3'd4, 0);
        readback("R12 written, invalid", 7, 0, tag_m[7]);
        look("R12 no hit", 32'h3300_0000);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin tag_m[i] = 0; dat_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_sizes();
        t_priority();
        t_timing();
        t_readback();
        t_inv_page();
        t_inv_all();
        t_collide();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule